// File: doc/BRIEF.md
# Inactivity Power State Controller

This controller watches three activity strobes and lowers the system's power level one step at a time as idle periods lengthen. The four levels, from most to least power, are full-on, doze, stand-by and suspend. One stage counter measures idle time in every state except suspend. A millisecond-style tick, made by dividing the core clock, advances it. The reload value in use depends on the current state. When the stage counter runs out, the block records why and raises an interrupt request to the management software. If automatic mode is on, the block also makes the step itself.

System activity in a lowered state is a wake event. Housekeeping activity in doze or stand-by starts a short burst window. During that window the stage counter is frozen and the clock-stop output uses the full-on duty, and the state does not change. A separate peripheral counter reports a peripheral that has stayed quiet for too long. A clock-stop request output is pulse-width modulated with a duty programmed for each state. A set of power-plane enables drops the masked planes while in suspend.

Top module: `pwr_state_ctrl`

## Requirements
- R1: One cycle after reset is released, `pwr_state` is 0 (full-on), `smi_req` is 0, `smi_cause` is 0, `susp_req` is 0 and every `plane_en` bit is 1.
- R2: In full-on, a doze reload of N (address 0) sets cause bit 0 and raises `smi_req` on the N-th tick after the last system strobe. One tick is CLK_DIV clocks. In automatic mode (control address 5, bit 0) the state becomes 1 (doze) at the same edge.
- R3: In doze, the stand-by reload (address 1) sets cause bit 1, and in automatic mode the state steps to 2. In stand-by, the suspend reload (address 2) sets cause bit 2, and in automatic mode the state steps to 3. On entry to suspend, `plane_en` becomes the inverse of the plane-off mask (control bits 4 upward). Outside suspend all planes are on.
- R4: A reload value of 0 disables that counter, and it never raises a cause.
- R5: A system strobe reloads the running stage counter, so that expiry is measured from the last strobe.
- R6: A system strobe while the state is not full-on sets cause bit 4 (wake). In automatic mode it returns the state to full-on. Otherwise the state is unchanged.
- R7: When the state leaves suspend, every `plane_en` bit is 1 one cycle before `pwr_state` changes.
- R8: Outside automatic mode an expiry only records its cause. A write to address 7 sets the state to data bits [1:0], with 0 full-on, 1 doze, 2 stand-by and 3 suspend.
- R9: `smi_req` is high while any cause bit is set. It stays high until a `smi_ack` pulse, which clears all cause bits at the next edge.
- R10: In doze or stand-by, a housekeeping strobe loads the burst counter (address 3). While that counter runs, the stage counter does not count and `susp_req` uses the full-on duty. Housekeeping strobes in full-on or suspend are ignored, and they never reload the stage counter.
- R11: A peripheral reload of N (address 4) sets cause bit 3 on the N-th tick after the last peripheral strobe.
- R12: Address 6 holds a 4-bit duty per state: bits [3:0] full-on, [7:4] doze, [11:8] stand-by, [15:12] suspend. Over any 16 consecutive clocks, `susp_req` is high for exactly the current duty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| sys_act | input | 1 | System activity strobe |
| hk_act | input | 1 | Housekeeping activity strobe |
| per_act | input | 1 | Peripheral activity strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| smi_ack | input | 1 | Software acknowledge, clears causes |
| smi_req | output | 1 | Management interrupt request |
| smi_cause | output | 5 | Cause bits: 0 doze, 1 stand-by, 2 suspend, 3 peripheral, 4 wake |
| susp_req | output | 1 | Modulated clock-stop request |
| plane_en | output | N_PLANES | Board power-plane enables |
| pwr_state | output | 2 | Current power state |

## Verification
A wrong stage counter shows up as a cause bit and `smi_req` rising outside a window of one tick around N ticks after the last strobe. A wrong state or duty register shows up within 16 clocks as a wrong high count on `susp_req`. A plane sequencing error shows up on the single clock between the wake strobe and the change of `pwr_state`, so the bench samples that cycle directly. A held or frozen cause register shows up as `smi_req` staying high after an acknowledge, or dropping before one.

// File: rtl/pwr_pkg.sv
package pwr_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 3;
    localparam int DUTY_W  = 4;
    localparam int N_TMR   = 3;
    localparam int T_STAGE = 0;
    localparam int T_HK    = 1;
    localparam int T_PER   = 2;

    typedef enum logic [1:0] {
        PS_FULL = 2'd0,
        PS_DOZE = 2'd1,
        PS_STBY = 2'd2,
        PS_SUSP = 2'd3
    } pwr_state_e;

    typedef struct packed {
        logic wake;
        logic periph;
        logic susp;
        logic stby;
        logic doze;
    } cause_t;

    localparam logic [ADDR_W-1:0] A_RL_DOZE = 3'd0;
    localparam logic [ADDR_W-1:0] A_RL_STBY = 3'd1;
    localparam logic [ADDR_W-1:0] A_RL_SUSP = 3'd2;
    localparam logic [ADDR_W-1:0] A_RL_HK   = 3'd3;
    localparam logic [ADDR_W-1:0] A_RL_PER  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CTRL    = 3'd5;
    localparam logic [ADDR_W-1:0] A_DUTY    = 3'd6;
    localparam logic [ADDR_W-1:0] A_CMD     = 3'd7;

    function automatic pwr_state_e next_deeper(input pwr_state_e s);
        case (s)
            PS_FULL: return PS_DOZE;
            PS_DOZE: return PS_STBY;
            default: return PS_SUSP;
        endcase
    endfunction

    function automatic logic [DUTY_W-1:0] pick_duty(input logic [4*DUTY_W-1:0] word,
                                                    input pwr_state_e s);
        return word[DUTY_W*int'(s) +: DUTY_W];
    endfunction

endpackage

// File: rtl/pwr_tick_gen.sv
module pwr_tick_gen #(
    parameter int CLK_DIV = 250000
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(CLK_DIV - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q <= '0;
            tick  <= 1'b0;
        end else begin
            tick <= (div_q == LAST);
            if (div_q == LAST) div_q <= '0;
            else               div_q <= div_q + 1'b1;
        end
    end

    generate
        if (CLK_DIV > 1) begin : g_gap_chk
            AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick); // R2
        end
    endgenerate

endmodule

// File: rtl/pwr_down_cnt.sv
module pwr_down_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] init_val,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         hold,
    output logic         busy,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= init_val;
            expire <= 1'b0;
        end else begin
            expire <= 1'b0;
            if (load) begin
                cnt <= load_val;
            end else if (tick && !hold && cnt != '0) begin
                cnt <= cnt - 1'b1;
                if (cnt == W'(1)) expire <= 1'b1;
            end
        end
    end

    assign busy = (cnt != '0);

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!$past(load) && $past(cnt) == '0) |-> cnt == '0); // R4
    AST_EXP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        expire |-> cnt == '0); // R2

endmodule

// File: rtl/pwr_susp_mod.sv
module pwr_susp_mod
    import pwr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DUTY_W-1:0] duty,
    output logic              susp_req
);
    logic [DUTY_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            susp_req <= 1'b0;
        end else begin
            phase_q  <= phase_q + 1'b1;
            susp_req <= (phase_q < duty);
        end
    end

    AST_DUTY_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
        ($past(duty) == '0) |-> !susp_req); // R12

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
    import pwr_pkg::*;
#(
    parameter int                CLK_DIV   = 250000,
    parameter int                N_PLANES  = 4,
    parameter logic [DATA_W-1:0] DOZE_INIT = 16'd1000,
    parameter logic [DATA_W-1:0] STBY_INIT = 16'd5000,
    parameter logic [DATA_W-1:0] SUSP_INIT = 16'd30000,
    parameter logic [DATA_W-1:0] HK_INIT   = 16'd50,
    parameter logic [DATA_W-1:0] PER_INIT  = 16'd2000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                sys_act,
    input  logic                hk_act,
    input  logic                per_act,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic                smi_ack,
    output logic                smi_req,
    output logic [4:0]          smi_cause,
    output logic                susp_req,
    output logic [N_PLANES-1:0] plane_en,
    output logic [1:0]          pwr_state
);
    localparam int MASK_LSB = 4;

    // configuration registers
    logic [DATA_W-1:0]   rl_doze, rl_stby, rl_susp, rl_hk, rl_per;
    logic                auto_en;
    logic [N_PLANES-1:0] off_mask;
    logic [DATA_W-1:0]   duty_word;

    always_ff @(posedge clk) begin
        if (rst) begin
            rl_doze   <= DOZE_INIT;
            rl_stby   <= STBY_INIT;
            rl_susp   <= SUSP_INIT;
            rl_hk     <= HK_INIT;
            rl_per    <= PER_INIT;
            auto_en   <= 1'b0;
            off_mask  <= '0;
            duty_word <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_RL_DOZE: rl_doze <= reg_wdata;
                A_RL_STBY: rl_stby <= reg_wdata;
                A_RL_SUSP: rl_susp <= reg_wdata;
                A_RL_HK:   rl_hk   <= reg_wdata;
                A_RL_PER:  rl_per  <= reg_wdata;
                A_CTRL: begin
                    auto_en  <= reg_wdata[0];
                    off_mask <= reg_wdata[MASK_LSB +: N_PLANES];
                end
                A_DUTY:    duty_word <= reg_wdata;
                default: ;
            endcase
        end
    end

    logic       cmd_wr;
    pwr_state_e cmd_tgt;
    assign cmd_wr  = reg_wr && (reg_addr == A_CMD);
    assign cmd_tgt = pwr_state_e'(reg_wdata[1:0]);

    // tick and the three counters
    logic tick;
    pwr_tick_gen #(.CLK_DIV(CLK_DIV)) i_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    logic              t_load [N_TMR];
    logic [DATA_W-1:0] t_val  [N_TMR];
    logic [DATA_W-1:0] t_init [N_TMR];
    logic              t_hold [N_TMR];
    logic              t_busy [N_TMR];
    logic              t_exp  [N_TMR];

    genvar gi;
    generate
        for (gi = 0; gi < N_TMR; gi++) begin : g_tmr
            pwr_down_cnt #(.W(DATA_W)) i_cnt (
                .clk      (clk),
                .rst      (rst),
                .init_val (t_init[gi]),
                .tick     (tick),
                .load     (t_load[gi]),
                .load_val (t_val[gi]),
                .hold     (t_hold[gi]),
                .busy     (t_busy[gi]),
                .expire   (t_exp[gi])
            );
        end
    endgenerate

    // state machine
    pwr_state_e          state_q, state_nxt, pend_tgt_q, pend_tgt;
    logic                pend_q, pend_start;
    logic                chg;
    cause_t              cause_q, cause_set;
    logic [N_PLANES-1:0] plane_q;
    logic [DATA_W-1:0]   stage_rl;
    logic                stage_exp, hk_run, in_light;

    assign stage_exp = t_exp[T_STAGE];
    assign hk_run    = t_busy[T_HK];
    assign in_light  = (state_q == PS_DOZE) || (state_q == PS_STBY);

    always_comb begin
        state_nxt  = state_q;
        pend_start = 1'b0;
        pend_tgt   = PS_FULL;
        if (pend_q) begin
            state_nxt = pend_tgt_q;
        end else if (cmd_wr) begin
            if (state_q == PS_SUSP && cmd_tgt != PS_SUSP) begin
                pend_start = 1'b1;
                pend_tgt   = cmd_tgt;
            end else begin
                state_nxt = cmd_tgt;
            end
        end else if (auto_en) begin
            if (sys_act && state_q != PS_FULL) begin
                if (state_q == PS_SUSP) pend_start = 1'b1;
                else                    state_nxt  = PS_FULL;
            end else if (stage_exp) begin
                state_nxt = next_deeper(state_q);
            end
        end
    end

    assign chg = (state_nxt != state_q);

    always_comb begin
        case (state_nxt)
            PS_FULL: stage_rl = rl_doze;
            PS_DOZE: stage_rl = rl_stby;
            PS_STBY: stage_rl = rl_susp;
            default: stage_rl = '0;
        endcase
    end

    always_comb begin
        t_init[T_STAGE] = DOZE_INIT;
        t_load[T_STAGE] = sys_act || chg;
        t_val[T_STAGE]  = stage_rl;
        t_hold[T_STAGE] = hk_run;

        t_init[T_HK]    = '0;
        t_load[T_HK]    = (hk_act && in_light) || chg;
        t_val[T_HK]     = chg ? '0 : rl_hk;
        t_hold[T_HK]    = 1'b0;

        t_init[T_PER]   = PER_INIT;
        t_load[T_PER]   = per_act;
        t_val[T_PER]    = rl_per;
        t_hold[T_PER]   = 1'b0;
    end

    always_comb begin
        cause_set        = '0;
        cause_set.doze   = stage_exp && (state_q == PS_FULL);
        cause_set.stby   = stage_exp && (state_q == PS_DOZE);
        cause_set.susp   = stage_exp && (state_q == PS_STBY);
        cause_set.periph = t_exp[T_PER];
        cause_set.wake   = sys_act && (state_q != PS_FULL);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= PS_FULL;
            pend_q     <= 1'b0;
            pend_tgt_q <= PS_FULL;
            cause_q    <= '0;
            plane_q    <= '1;
        end else begin
            state_q <= state_nxt;
            cause_q <= (smi_ack ? cause_t'('0) : cause_q) | cause_set;
            if (pend_start) begin
                pend_q     <= 1'b1;
                pend_tgt_q <= pend_tgt;
                plane_q    <= '1;
            end else begin
                pend_q <= 1'b0;
                if (state_nxt == PS_SUSP && state_q != PS_SUSP) plane_q <= ~off_mask;
            end
        end
    end

    pwr_susp_mod i_mod (
        .clk      (clk),
        .rst      (rst),
        .duty     (pick_duty(duty_word, hk_run ? PS_FULL : state_q)),
        .susp_req (susp_req)
    );

    assign smi_cause = cause_q;
    assign smi_req   = |cause_q;
    assign plane_en  = plane_q;
    assign pwr_state = state_q;

    AST_PLANES_BEFORE_RESUME: assert property (@(posedge clk) disable iff (rst)
        ($past(state_q) == PS_SUSP && state_q != PS_SUSP) |-> &$past(plane_q)); // R7
    AST_PLANES_ON_AWAKE: assert property (@(posedge clk) disable iff (rst)
        (state_q != PS_SUSP) |-> &plane_q); // R3
    AST_SMI_HELD: assert property (@(posedge clk) disable iff (rst)
        (smi_req && !smi_ack) |=> smi_req); // R9
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q != $past(state_q) && state_q != PS_FULL && !$past(cmd_wr)
         && $past(state_q) != PS_SUSP) |-> state_q == next_deeper($past(state_q))); // R3

endmodule

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
    localparam int P = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sys_act = 0, hk_act = 0, per_act = 0, reg_wr = 0, smi_ack = 0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        smi_req, susp_req;
    logic [4:0]  smi_cause;
    logic [3:0]  plane_en;
    logic [1:0]  pwr_state;

    int n_run = 0, n_fail = 0, cyc = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pwr_state_ctrl #(
        .CLK_DIV(P), .N_PLANES(4),
        .DOZE_INIT(16'd0), .STBY_INIT(16'd0), .SUSP_INIT(16'd0),
        .HK_INIT(16'd0), .PER_INIT(16'd0)
    ) i_pwr_state_ctrl (
        .clk(clk), .rst(rst), .sys_act(sys_act), .hk_act(hk_act), .per_act(per_act),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .smi_ack(smi_ack),
        .smi_req(smi_req), .smi_cause(smi_cause), .susp_req(susp_req),
        .plane_en(plane_en), .pwr_state(pwr_state)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_win(input string req, input int v, input int lo, input int hi);
        n_run++;
        if (v < lo || v > hi) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, v, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask
    task automatic p_sys; @(negedge clk); sys_act = 1; @(negedge clk); sys_act = 0; endtask
    task automatic p_hk;  @(negedge clk); hk_act  = 1; @(negedge clk); hk_act  = 0; endtask
    task automatic p_per; @(negedge clk); per_act = 1; @(negedge clk); per_act = 0; endtask
    task automatic p_ack; @(negedge clk); smi_ack = 1; @(negedge clk); smi_ack = 0; endtask

    task automatic wait_smi(output int at);
        at = -1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (smi_req) begin at = cyc; break; end
        end
    endtask

    task automatic duty_cnt(output int n);
        repeat (4) @(negedge clk);
        n = 0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            n += int'(susp_req);
        end
    endtask

    task automatic do_reset;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int t0, at, n;
        do_reset();
        // R1 reset state
        chk(pwr_state == 2'd0, "R1 state", pwr_state, 0);
        chk(!smi_req, "R1 smi", smi_req, 0);
        chk(smi_cause == 0, "R1 cause", smi_cause, 0);
        chk(!susp_req, "R1 susp_req", susp_req, 0);
        chk(plane_en == 4'hF, "R1 planes", plane_en, 15);

        // R12 duty sweep in full-on
        for (int d = 0; d < 16; d++) begin
            wr(3'd6, 16'(d));
            duty_cnt(n);
            chk(n == d, "R12 full-on duty", n, d);
        end
        wr(3'd6, 16'h0000);

        // R2/R8 manual-mode doze expiry, R9 hold and ack
        wr(3'd0, 16'd5);
        p_sys(); t0 = cyc;
        wait_smi(at);
        chk_win("R2 doze expiry time", at - t0, 4 * P, 5 * P + 3);
        chk(smi_cause == 5'b00001, "R2 doze cause", smi_cause, 1);
        chk(pwr_state == 2'd0, "R8 no auto step", pwr_state, 0);
        repeat (40) @(negedge clk);
        chk(smi_req, "R9 held until ack", smi_req, 1);
        p_ack();
        chk(!smi_req && smi_cause == 0, "R9 ack clears", smi_cause, 0);

        // R4 zero reload disables
        wr(3'd0, 16'd0);
        p_sys();
        repeat (200) @(negedge clk);
        chk(!smi_req, "R4 disabled timer", smi_req, 0);

        // R5 activity reloads stage counter
        wr(3'd0, 16'd10);
        p_sys();
        repeat (30) @(negedge clk);
        chk(!smi_req, "R5 no early expiry", smi_req, 0);
        p_sys(); t0 = cyc;
        wait_smi(at);
        chk_win("R5 expiry from last strobe", at - t0, 9 * P, 10 * P + 3);
        p_ack();

        // R6 manual wake, R8 command
        wr(3'd0, 16'd0);
        p_sys();
        wr(3'd7, 16'd1);
        chk(pwr_state == 2'd1, "R8 command to doze", pwr_state, 1);
        p_sys();
        chk(smi_cause == 5'b10000, "R6 wake cause", smi_cause, 16);
        chk(pwr_state == 2'd1, "R6 manual stays", pwr_state, 1);
        p_ack();

        // R10 housekeeping burst in doze
        wr(3'd1, 16'd30);
        wr(3'd3, 16'd20);
        wr(3'd6, 16'h003C);
        wr(3'd7, 16'd0);
        wr(3'd7, 16'd1); t0 = cyc;
        duty_cnt(n);
        chk(n == 3, "R12 doze duty", n, 3);
        p_hk();
        duty_cnt(n);
        chk(n == 12, "R10 burst uses full-on duty", n, 12);
        wait_smi(at);
        chk_win("R10 stage frozen during burst", at - t0, 47 * P, 51 * P + 4);
        chk(smi_cause == 5'b00010, "R3 stand-by cause", smi_cause, 2);
        chk(pwr_state == 2'd1, "R10 state kept", pwr_state, 1);
        p_ack();

        // R10 housekeeping ignored in full-on
        wr(3'd7, 16'd0);
        wr(3'd0, 16'd5);
        p_sys(); t0 = cyc;
        for (int k = 0; k < 3; k++) begin
            repeat (2) @(negedge clk);
            p_hk();
        end
        wait_smi(at);
        chk_win("R10 no reload by housekeeping", at - t0, 4 * P, 5 * P + 3);
        chk(smi_cause == 5'b00001, "R10 doze cause", smi_cause, 1);
        p_ack();
        wr(3'd0, 16'd0);
        p_sys();

        // R11 peripheral timeout
        wr(3'd4, 16'd6);
        p_per(); t0 = cyc;
        wait_smi(at);
        chk_win("R11 peripheral time", at - t0, 5 * P, 6 * P + 3);
        chk(smi_cause == 5'b01000, "R11 peripheral cause", smi_cause, 8);
        p_ack();
        wr(3'd4, 16'd0);
        p_per();

        // R8 command into suspend, R7 planes first on exit
        wr(3'd5, 16'h0030);
        wr(3'd6, 16'h9000);
        wr(3'd7, 16'd3);
        chk(pwr_state == 2'd3, "R8 command suspend", pwr_state, 3);
        chk(plane_en == 4'b1100, "R3 masked planes off", plane_en, 12);
        duty_cnt(n);
        chk(n == 9, "R12 suspend duty", n, 9);
        wr(3'd7, 16'd0);
        chk(plane_en == 4'hF && pwr_state == 2'd3, "R7 planes first", plane_en, 15);
        @(negedge clk);
        chk(pwr_state == 2'd0, "R7 state after planes", pwr_state, 0);

        // R2/R3/R6/R7 automatic chain
        do_reset();
        wr(3'd6, 16'h0000);
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd4);
        wr(3'd2, 16'd5);
        wr(3'd5, 16'h0051);
        p_sys(); t0 = cyc;
        wait_smi(at);
        chk_win("R2 auto doze time", at - t0, 2 * P, 3 * P + 3);
        chk(smi_cause == 5'b00001, "R2 auto doze cause", smi_cause, 1);
        chk(pwr_state == 2'd1, "R2 auto to doze", pwr_state, 1);
        p_ack(); t0 = cyc;
        wait_smi(at);
        chk_win("R3 auto stand-by time", at - t0, 3 * P - 3, 4 * P + 3);
        chk(smi_cause == 5'b00010, "R3 auto stand-by cause", smi_cause, 2);
        chk(pwr_state == 2'd2, "R3 auto to stand-by", pwr_state, 2);
        p_ack(); t0 = cyc;
        wait_smi(at);
        chk_win("R3 auto suspend time", at - t0, 4 * P - 3, 5 * P + 3);
        chk(smi_cause == 5'b00100, "R3 auto suspend cause", smi_cause, 4);
        chk(pwr_state == 2'd3, "R3 auto to suspend", pwr_state, 3);
        chk(plane_en == 4'b1010, "R3 suspend planes", plane_en, 10);
        p_ack();
        p_sys();
        chk(plane_en == 4'hF, "R7 planes up first", plane_en, 15);
        chk(pwr_state == 2'd3, "R7 state not yet changed", pwr_state, 3);
        @(negedge clk);
        chk(pwr_state == 2'd0, "R6 auto wake to full-on", pwr_state, 0);
        chk(smi_cause == 5'b10000, "R6 auto wake cause", smi_cause, 16);
        p_ack();
        chk(!smi_req, "R9 cleared after wake ack", smi_req, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule